// File: doc/BRIEF.md
# Byte-Packing Data Register Buffer

This block is the four-byte holding store that sits behind a 16-bit software data register of a serial controller. Software writes a full 16-bit word or a single byte for transmission. It reads 16-bit words of received bytes. One control input selects which half of a data word maps to the earlier byte on the wire. Transmit and receive have separate fill counts.

The serial sequencer drains transmit bytes through a pop strobe and deposits received bytes through a push strobe. The block keeps six status flags: single-byte leftover, receive overrun, transmit underflow, transmit ready, receive ready and access ready. The buffer updates these flags itself on data accesses and sequencer strobes. The sequencer can also raise some flags directly, and software clears any flag by writing ones.

Top module: `bytepack_top`

## Requirements
- R1: After reset both fill counts are zero, `status` is zero and `rdData` is zero.
- R2: With `byteOrder` low, a 16-bit write held with room adds two bytes to the transmit fill. The low byte of `wrData` pops before the high byte, and earlier writes pop before later ones.
- R3: With `byteOrder` high, a 16-bit write puts its high byte on the wire first. A read returns the earliest received byte in bits 15:8 instead of bits 7:0.
- R4: A byte write (`wrByte` high) adds `wrData[7:0]` as one byte, popped after the bytes already held.
- R5: Any data write is dropped, leaving transmit fill and buffer contents unchanged, while the transmit fill is above two.
- R6: An accepted write clears transmit underflow (status bit 10). If the new transmit fill exceeds two, it also clears transmit ready (status bit 4).
- R7: A push with receive fill n below four stores the byte at bits 8n+7:8n and increments the fill. A push at fill zero first discards old contents. A push sets receive ready (status bit 3), and a push at fill four is ignored.
- R8: A read returns received bytes 0 and 1. With two or more held, the fill drops by two, and above two the remaining bytes move down by 16 bits.
- R9: A read with exactly one byte held sets the single-byte flag (status bit 15) and drops the receive fill to zero.
- R10: A read that leaves the receive fill at zero clears receive ready. If `masterOn` is high and `txDir` is low, the same read pulses `masterClr` during that cycle and sets access ready (status bit 2).
- R11: Every read clears receive overrun (status bit 11). A read with nothing held returns the current contents and keeps the fill at zero.
- R12: `setUnderflow`, `setOverrun` and `setTxReady` raise status bits 10, 11 and 4. A one in `statusClr` clears that status bit. A raise wins over any clear in the same cycle.
- R13: A push or pop in a cycle with a software read or write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteOrder | input | 1 | 1: high half of a word is the earlier byte |
| wrEn | input | 1 | Software data write strobe |
| wrByte | input | 1 | Write carries one byte instead of two |
| wrData | input | 16 | Software write data |
| rdEn | input | 1 | Software data read strobe |
| rdData | output | 16 | Read data (current bytes 0 and 1) |
| masterOn | input | 1 | Controller is bus master |
| txDir | input | 1 | 1: transmit direction, 0: receive |
| masterClr | output | 1 | Pulse: drop master mode (access complete) |
| popEn | input | 1 | Sequencer takes one transmit byte |
| popByte | output | 8 | Next transmit byte |
| pushEn | input | 1 | Sequencer delivers one received byte |
| pushByte | input | 8 | Received byte |
| txFill | output | 3 | Transmit bytes held |
| rxFill | output | 3 | Receive bytes held |
| setUnderflow | input | 1 | Raise transmit underflow |
| setOverrun | input | 1 | Raise receive overrun |
| setTxReady | input | 1 | Raise transmit ready |
| statusClr | input | 16 | Write-one-to-clear mask for status |
| status | output | 16 | Status flags (bits 15, 11, 10, 4, 3, 2) |

## Verification
The hardest state to reach is a buffer holding mixed word and byte writes at a fill of three. In that state a further word write and a further byte write must both be dropped, and the pop order must still interleave the halves correctly. The stimulus reaches it by a word write followed by a byte write. The test then attempts both rejected writes and drains the buffer, checking each popped byte. A second hard case is a read collision with the sequencer. To cover it, push and pop strobes are driven in the same cycle as a software write or read, and the fills are checked afterwards.

// File: rtl/bytepack_pkg.sv
package bytepack_pkg;
  typedef struct packed {
    logic wr16;
    logic wr8;
    logic rd;
    logic push;
    logic pop;
  } packStrobe_t;

  localparam int ST_SINGLE    = 15;
  localparam int ST_OVERRUN   = 11;
  localparam int ST_UNDERFLOW = 10;
  localparam int ST_TXREADY   = 4;
  localparam int ST_RXREADY   = 3;
  localparam int ST_ACCREADY  = 2;
endpackage

// File: rtl/bytepack_dp.sv
module bytepack_dp
  import bytepack_pkg::*;
#(
  parameter int BUF_BYTES = 4,
  parameter int WORD_W    = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  packStrobe_t                   strb,
  input  logic                          byteOrder,
  input  logic [WORD_W-1:0]             wrData,
  input  logic [7:0]                    pushByte,
  output logic [WORD_W-1:0]             rdData,
  output logic [7:0]                    popByte,
  output logic [$clog2(BUF_BYTES+1)-1:0] txFill,
  output logic [$clog2(BUF_BYTES+1)-1:0] rxFill
);
  localparam int BUF_W = BUF_BYTES * 8;
  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  logic [BUF_W-1:0]  bufQ, bufD;
  logic [CNT_W-1:0]  txQ, txD, rxQ, rxD;
  logic [WORD_W-1:0] ordered;

  assign ordered = byteOrder ? wrData : {wrData[7:0], wrData[15:8]};
  assign rdData  = byteOrder ? {bufQ[7:0], bufQ[15:8]} : bufQ[15:0];
  assign txFill  = txQ;
  assign rxFill  = rxQ;

  always_comb begin
    popByte = '0;
    for (int i = 0; i < BUF_BYTES; i++) begin
      if (CNT_W'(i + 1) == txQ) popByte = bufQ[i*8 +: 8];
    end
  end

  always_comb begin
    bufD = bufQ;
    txD  = txQ;
    rxD  = rxQ;
    if (strb.wr16) begin
      bufD = {bufQ[BUF_W-WORD_W-1:0], ordered};
      txD  = txQ + CNT_W'(2);
    end else if (strb.wr8) begin
      bufD = {bufQ[BUF_W-9:0], wrData[7:0]};
      txD  = txQ + CNT_W'(1);
    end else if (strb.rd) begin
      if (rxQ == CNT_W'(1)) begin
        rxD = '0;
      end else if (rxQ > CNT_W'(1)) begin
        if (rxQ > CNT_W'(2)) bufD = bufQ >> WORD_W;
        rxD = rxQ - CNT_W'(2);
      end
    end else if (strb.push) begin
      if (rxQ == '0) bufD = BUF_W'(pushByte);
      else           bufD = bufQ | (BUF_W'(pushByte) << {rxQ, 3'b000});
      rxD = rxQ + CNT_W'(1);
    end else if (strb.pop) begin
      txD = txQ - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ <= '0;
      txQ  <= '0;
      rxQ  <= '0;
    end else begin
      bufQ <= bufD;
      txQ  <= txD;
      rxQ  <= rxD;
    end
  end
endmodule

// File: rtl/bytepack_ctl.sv
module bytepack_ctl
  import bytepack_pkg::*;
#(
  parameter int BUF_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic                          wrByte,
  input  logic                          rdEn,
  input  logic                          pushEn,
  input  logic                          popEn,
  input  logic [$clog2(BUF_BYTES+1)-1:0] txFill,
  input  logic [$clog2(BUF_BYTES+1)-1:0] rxFill,
  input  logic                          masterOn,
  input  logic                          txDir,
  input  logic                          setUnderflow,
  input  logic                          setOverrun,
  input  logic                          setTxReady,
  input  logic [15:0]                   statusClr,
  output packStrobe_t                   strb,
  output logic                          masterClr,
  output logic [15:0]                   status
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  logic        room, swAcc, rxEmptyAfter, txOverTwo;
  logic [15:0] stQ, stD;

  assign room  = txFill <= CNT_W'(BUF_BYTES - 2);
  assign swAcc = wrEn | rdEn;

  always_comb begin
    strb.wr16 = wrEn & ~wrByte & room;
    strb.wr8  = wrEn & wrByte & room;
    strb.rd   = rdEn & ~wrEn;
    strb.push = pushEn & ~swAcc & (rxFill < CNT_W'(BUF_BYTES));
    strb.pop  = popEn & ~swAcc & (txFill != '0);
  end

  assign rxEmptyAfter = rxFill <= CNT_W'(2);
  assign txOverTwo    = strb.wr16 ? (txFill != '0) : (txFill >= CNT_W'(2));
  assign masterClr    = strb.rd & rxEmptyAfter & masterOn & ~txDir;

  always_comb begin
    stD = stQ & ~statusClr;
    if (strb.wr16 | strb.wr8) begin
      stD[ST_UNDERFLOW] = 1'b0;
      if (txOverTwo) stD[ST_TXREADY] = 1'b0;
    end
    if (strb.rd) begin
      stD[ST_OVERRUN] = 1'b0;
      if (rxFill == CNT_W'(1)) stD[ST_SINGLE] = 1'b1;
      if (rxEmptyAfter) stD[ST_RXREADY] = 1'b0;
      if (masterClr) stD[ST_ACCREADY] = 1'b1;
    end
    if (strb.push)   stD[ST_RXREADY]   = 1'b1;
    if (setUnderflow) stD[ST_UNDERFLOW] = 1'b1;
    if (setOverrun)   stD[ST_OVERRUN]   = 1'b1;
    if (setTxReady)   stD[ST_TXREADY]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= '0;
    else       stQ <= stD;
  end

  assign status = stQ;
endmodule

// File: rtl/bytepack_top.sv
module bytepack_top
  import bytepack_pkg::*;
#(
  parameter int BUF_BYTES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteOrder,
  input  logic        wrEn,
  input  logic        wrByte,
  input  logic [15:0] wrData,
  input  logic        rdEn,
  output logic [15:0] rdData,
  input  logic        masterOn,
  input  logic        txDir,
  output logic        masterClr,
  input  logic        popEn,
  output logic [7:0]  popByte,
  input  logic        pushEn,
  input  logic [7:0]  pushByte,
  output logic [2:0]  txFill,
  output logic [2:0]  rxFill,
  input  logic        setUnderflow,
  input  logic        setOverrun,
  input  logic        setTxReady,
  input  logic [15:0] statusClr,
  output logic [15:0] status
);
  packStrobe_t strb;

  bytepack_ctl #(.BUF_BYTES(BUF_BYTES)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByte(wrByte), .rdEn(rdEn),
    .pushEn(pushEn), .popEn(popEn), .txFill(txFill), .rxFill(rxFill),
    .masterOn(masterOn), .txDir(txDir), .setUnderflow(setUnderflow),
    .setOverrun(setOverrun), .setTxReady(setTxReady), .statusClr(statusClr),
    .strb(strb), .masterClr(masterClr), .status(status)
  );

  bytepack_dp #(.BUF_BYTES(BUF_BYTES), .WORD_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteOrder(byteOrder),
    .wrData(wrData), .pushByte(pushByte), .rdData(rdData),
    .popByte(popByte), .txFill(txFill), .rxFill(rxFill)
  );
endmodule

// File: rtl/bytepack_chk.sv
module bytepack_chk #(
  parameter int BUF_BYTES = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        wrByte,
  input logic        rdEn,
  input logic        pushEn,
  input logic        masterOn,
  input logic        txDir,
  input logic        masterClr,
  input logic        setUnderflow,
  input logic        setOverrun,
  input logic [2:0]  txFill,
  input logic [2:0]  rxFill,
  input logic [15:0] status
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(txFill) <= BUF_BYTES && int'(rxFill) <= BUF_BYTES); // R7

  AST_WR_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && int'(txFill) > BUF_BYTES - 2 |=> $stable(txFill)); // R5

  AST_WR_CLR_UDF: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && int'(txFill) <= BUF_BYTES - 2 && !setUnderflow |=> !status[10]); // R6

  AST_SINGLE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !wrEn && rxFill == 3'd1 |=> status[15] && rxFill == 3'd0); // R9

  AST_MCLR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    masterClr |-> rdEn && masterOn && !txDir && rxFill <= 3'd2); // R10

  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !wrEn && !setOverrun |=> !status[11]); // R11

  AST_PUSH_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    pushEn && wrEn |=> $stable(rxFill)); // R13
endmodule

bind bytepack_top bytepack_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByte(wrByte), .rdEn(rdEn),
  .pushEn(pushEn), .masterOn(masterOn), .txDir(txDir), .masterClr(masterClr),
  .setUnderflow(setUnderflow), .setOverrun(setOverrun),
  .txFill(txFill), .rxFill(rxFill), .status(status)
);

// File: tb/bytepack_top_tb.sv
module bytepack_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteOrder = 1'b0, wrEn = 1'b0, wrByte = 1'b0, rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        masterOn = 1'b0, txDir = 1'b0;
  logic        popEn = 1'b0, pushEn = 1'b0;
  logic [7:0]  pushByte = '0;
  logic        setUnderflow = 1'b0, setOverrun = 1'b0, setTxReady = 1'b0;
  logic [15:0] statusClr = '0;
  logic [15:0] rdData, status;
  logic        masterClr;
  logic [7:0]  popByte;
  logic [2:0]  txFill, rxFill;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bytepack_top u_dut (
    .clk(clk), .rstN(rstN), .byteOrder(byteOrder), .wrEn(wrEn), .wrByte(wrByte),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .masterOn(masterOn),
    .txDir(txDir), .masterClr(masterClr), .popEn(popEn), .popByte(popByte),
    .pushEn(pushEn), .pushByte(pushByte), .txFill(txFill), .rxFill(rxFill),
    .setUnderflow(setUnderflow), .setOverrun(setOverrun), .setTxReady(setTxReady),
    .statusClr(statusClr), .status(status)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic isByte, input logic [15:0] v);
    wrEn = 1'b1; wrByte = isByte; wrData = v;
    cycle();
    wrEn = 1'b0; wrByte = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    popEn = 1'b1; #1 b = popByte;
    cycle();
    popEn = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    pushEn = 1'b1; pushByte = b;
    cycle();
    pushEn = 1'b0;
  endtask

  task automatic rd(output logic [15:0] d, output logic mc);
    rdEn = 1'b1; #1 d = rdData; mc = masterClr;
    cycle();
    rdEn = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 txFill", txFill, 0);
    check("R1 rxFill", rxFill, 0);
    check("R1 status", status, 0);
    check("R1 rdData", rdData, 0);
  endtask

  task automatic t_tx_low_first();
    logic [7:0] b;
    byteOrder = 1'b0;
    setTxReady = 1'b1; cycle(); setTxReady = 1'b0;
    check("R12 txReady raised", status[4], 1);
    wr(1'b0, 16'h1122);
    check("R2 fill after one word", txFill, 2);
    check("R6 txReady kept at fill 2", status[4], 1);
    wr(1'b0, 16'h3344);
    check("R6 txReady cleared at fill 4", status[4], 0);
    wr(1'b0, 16'h5566);
    check("R5 fill unchanged", txFill, 4);
    pop(b); check("R2 pop1", b, 8'h22);
    pop(b); check("R2 pop2", b, 8'h11);
    pop(b); check("R2 pop3", b, 8'h44);
    pop(b); check("R5 pop4 not overwritten", b, 8'h33);
    check("R2 drained", txFill, 0);
  endtask

  task automatic t_tx_high_first();
    logic [7:0] b;
    byteOrder = 1'b1;
    wr(1'b0, 16'hA1B2);
    pop(b); check("R3 pop1", b, 8'hA1);
    pop(b); check("R3 pop2", b, 8'hB2);
    byteOrder = 1'b0;
  endtask

  task automatic t_byte_write();
    logic [7:0] b;
    setUnderflow = 1'b1; cycle(); setUnderflow = 1'b0;
    check("R12 underflow raised", status[10], 1);
    wr(1'b0, 16'h1234);
    check("R6 underflow cleared", status[10], 0);
    wr(1'b1, 16'hFF56);
    check("R4 fill 3", txFill, 3);
    wr(1'b1, 16'h0099);
    wr(1'b0, 16'h7788);
    check("R5 fill stays 3", txFill, 3);
    pop(b); check("R4 pop1", b, 8'h34);
    pop(b); check("R4 pop2", b, 8'h12);
    pop(b); check("R4 pop3", b, 8'h56);
  endtask

  task automatic t_rx_words();
    logic [15:0] d; logic mc;
    masterOn = 1'b1; txDir = 1'b0;
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    push(8'h55);
    check("R7 fill capped", rxFill, 4);
    check("R7 rxReady", status[3], 1);
    rd(d, mc);
    check("R8 first word", d, 16'h2211);
    check("R10 no masterClr", mc, 0);
    check("R8 fill 2", rxFill, 2);
    rd(d, mc);
    check("R8 shifted word", d, 16'h4433);
    check("R10 masterClr pulse", mc, 1);
    check("R10 rxReady cleared", status[3], 0);
    check("R10 accReady", status[2], 1);
    statusClr = 16'h0004; cycle(); statusClr = '0;
    check("R12 clear accReady", status[2], 0);
    masterOn = 1'b0;
  endtask

  task automatic t_rx_swapped();
    logic [15:0] d; logic mc;
    byteOrder = 1'b1;
    push(8'hAA); push(8'hBB);
    rd(d, mc);
    check("R3 swapped read", d, 16'hAABB);
    byteOrder = 1'b0;
  endtask

  task automatic t_single_and_empty();
    logic [15:0] d; logic mc;
    push(8'h5A);
    setOverrun = 1'b1; cycle(); setOverrun = 1'b0;
    check("R12 overrun raised", status[11], 1);
    rd(d, mc);
    check("R9 data", d, 16'h005A);
    check("R9 single flag", status[15], 1);
    check("R9 fill zero", rxFill, 0);
    check("R11 overrun cleared", status[11], 0);
    setOverrun = 1'b1; cycle(); setOverrun = 1'b0;
    rd(d, mc);
    check("R11 empty read data", d, 16'h005A);
    check("R11 empty read fill", rxFill, 0);
    check("R11 overrun cleared again", status[11], 0);
    statusClr = 16'h8000; cycle(); statusClr = '0;
    check("R12 clear single", status[15], 0);
  endtask

  task automatic t_collide();
    logic [7:0] b;
    logic [15:0] d; logic mc;
    pushEn = 1'b1; pushByte = 8'h77;
    wr(1'b0, 16'h0102);
    pushEn = 1'b0;
    check("R13 push dropped on write", rxFill, 0);
    check("R13 write taken", txFill, 2);
    popEn = 1'b1;
    rd(d, mc);
    popEn = 1'b0;
    check("R13 pop dropped on read", txFill, 2);
    pop(b); check("R13 pop after", b, 8'h02);
    pop(b);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_low_first();
    t_tx_high_first();
    t_byte_write();
    t_rx_words();
    t_rx_swapped();
    t_single_and_empty();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule